// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block chooses which physical frame to give up when a new page must be brought in. It keeps three pieces of state for every frame: a use bit, a dirty bit and a small sweep counter. A circular hand walks the frames, but only while a victim has been asked for. Each frame it passes is either spared, because it was referenced since the last pass, or aged by one. A frame is given up once it has gone unreferenced for enough passes. Clean frames need one pass. Dirty frames need two, and the first of those passes raises a write-back request so the page can be saved before it is evicted.

The surrounding memory manager does four things. It reports each reference to a frame and each store that makes a frame dirty. It reports each finished write-back. It pulses a request whenever it needs a frame. The block answers each request with a one-cycle victim strobe that carries the frame index. The chosen frame is treated as freshly loaded. The disk transfers themselves and any background refilling of free frames are handled elsewhere.

Top module: `nth_clock_victim`

## Requirements
- R1: After reset, all use bits, dirty bits and sweep counters are zero, the hand is on frame 0, and neither the victim strobe nor the write-back strobe is high.
- R2: A reference report (`touch_valid` with `touch_idx`) sets that frame's use bit, so the next pass of the hand spares it.
- R3: The hand moves only while a search is in progress and examines exactly one frame per clock. A request sampled at clock edge e starts a search. The first frame is examined at edge e+1. If the victim is the k-th frame examined, `victim_valid` is high for the single cycle after edge e+k.
- R4: An examined frame whose use bit is set is skipped. Its use bit and its sweep counter are both cleared.
- R5: An examined clean frame whose use bit is clear is chosen as the victim. A clean frame has a threshold of one pass.
- R6: An examined dirty frame whose use bit is clear and whose counter is 0 is not chosen. Its counter becomes 1, and `wb_req_valid` pulses for one cycle with its index. The next unreferenced pass chooses it, because a dirty frame has a threshold of two passes. A write-back strobe never coincides with a victim strobe.
- R7: When every use bit is set at the start of a search, the hand clears all of them in one full revolution and then chooses the frame it started from.
- R8: After a victim is chosen, the hand points to the next frame, wrapping from the last frame to frame 0. The victim's use bit is set, and its counter and dirty bit are cleared.
- R9: A write-back completion (`wb_done_valid` with `wb_done_idx`) clears the frame's dirty bit, so the frame is then handled with the clean threshold. If a dirty report for the same frame arrives in the same cycle, the dirty report wins.
- R10: A reference to the frame under examination, arriving in the cycle it is examined, makes that frame count as used. The frame is skipped and its use bit stays set.
- R11: A victim request that arrives while a search is in progress is ignored. It starts no second search and produces no second victim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | A frame was referenced this cycle |
| touch_idx | input | IDX_W | Index of the referenced frame |
| mark_dirty_valid | input | 1 | A frame was written this cycle |
| mark_dirty_idx | input | IDX_W | Index of the written frame |
| wb_done_valid | input | 1 | A write-back has finished |
| wb_done_idx | input | IDX_W | Frame whose write-back finished |
| victim_req | input | 1 | Pulse to ask for a replacement frame |
| victim_valid | output | 1 | One-cycle strobe: a victim has been chosen |
| victim_idx | output | IDX_W | Index of the chosen frame |
| wb_req_valid | output | 1 | One-cycle strobe: a dirty frame needs saving |
| wb_req_idx | output | IDX_W | Index of the frame to save |

## Verification
Directed searches are run from specific starting states, and each one separates a different rule:
- A search straight after reset, with every frame untouched, pins the one-cycle latency.
- A search that meets a dirty frame and then a referenced frame shows the write-back pass, the skip of a used frame, and the three-cycle latency.
- A frame that is dirtied and then written back before the hand reaches it must be taken on the first pass without a write-back strobe. This is what distinguishes the clean threshold from the dirty one.
- Referencing all frames first forces the full clearing revolution, and the bench checks that the search returns to its starting frame.
- A reference that lands on the frame under the hand, and a second request sent mid-search, each have a distinct victim index or latency that the opposite behaviour would not produce.

After these, a long run of random references, dirty reports, completions and requests is compared every cycle against a frame-level model of the sweep rules.

// File: rtl/nclk_pkg.sv
package nclk_pkg;

    typedef enum logic {
        HAND_IDLE   = 1'b0,
        HAND_SWEEP  = 1'b1
    } hand_state_e;

endpackage

// File: rtl/nclk_onehot.sv
module nclk_onehot #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] oh
);

    always_comb begin
        oh = '0;
        for (int i = 0; i < N; i++) begin
            if (en && (idx == W'(i))) begin
                oh[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nclk_frame.sv
module nclk_frame #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_hit,
    input  logic             dirty_set,
    input  logic             dirty_clr,
    input  logic             skip,
    input  logic             age,
    input  logic             take,
    output logic             use_o,
    output logic             dirty_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic             use_b;
        logic             dirty_b;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) begin
            slot_d.cnt     = '0;
            slot_d.use_b   = 1'b1;
            slot_d.dirty_b = 1'b0;
        end else if (skip) begin
            slot_d.cnt   = '0;
            slot_d.use_b = 1'b0;
        end else if (age) begin
            slot_d.cnt = slot_q.cnt + 1'b1;
        end
        // a reference always leaves the use bit set, even while being swept
        if (ref_hit) begin
            slot_d.use_b = 1'b1;
        end
        if (dirty_clr) begin
            slot_d.dirty_b = 1'b0;
        end
        // a fresh store outranks a finished write-back
        if (dirty_set) begin
            slot_d.dirty_b = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign use_o   = slot_q.use_b;
    assign dirty_o = slot_q.dirty_b;
    assign cnt_o   = slot_q.cnt;

endmodule

// File: rtl/nth_clock_victim.sv
module nth_clock_victim #(
    parameter int NUM_FRAMES    = 8,
    parameter int CLEAN_CHANCES = 1,
    parameter int DIRTY_CHANCES = 2,
    localparam int IDX_W        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             mark_dirty_valid,
    input  logic [IDX_W-1:0] mark_dirty_idx,
    input  logic             wb_done_valid,
    input  logic [IDX_W-1:0] wb_done_idx,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             wb_req_valid,
    output logic [IDX_W-1:0] wb_req_idx
);
    import nclk_pkg::*;

    localparam int MAX_CH = (DIRTY_CHANCES > CLEAN_CHANCES) ? DIRTY_CHANCES : CLEAN_CHANCES;
    localparam int CNT_W  = $clog2(MAX_CH + 1);
    localparam int AGE_W  = CNT_W + 1;
    localparam logic [AGE_W-1:0] CLEAN_T  = AGE_W'(CLEAN_CHANCES);
    localparam logic [AGE_W-1:0] DIRTY_T  = AGE_W'(DIRTY_CHANCES);
    localparam logic [AGE_W-1:0] WB_T     = AGE_W'(DIRTY_CHANCES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    typedef struct packed {
        hand_state_e      state;
        logic [IDX_W-1:0] hand;
        logic             vv;
        logic [IDX_W-1:0] vidx;
        logic             wv;
        logic [IDX_W-1:0] widx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_FRAMES-1:0] ref_oh, dset_oh, dclr_oh;
    logic [NUM_FRAMES-1:0] use_v, dirty_v;
    logic [CNT_W-1:0]      cnt_v [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] skip_v, age_v, take_v;

    logic             sweeping, seen_used, cur_dirty, hit, raise_wb;
    logic [AGE_W-1:0] age_n, thresh;
    logic [IDX_W-1:0] hand_next;
    logic             busy_w;
    logic [IDX_W-1:0] hand_w;

    nclk_onehot #(.N(NUM_FRAMES), .W(IDX_W)) u_ref_dec (
        .en(touch_valid), .idx(touch_idx), .oh(ref_oh)
    );
    nclk_onehot #(.N(NUM_FRAMES), .W(IDX_W)) u_dset_dec (
        .en(mark_dirty_valid), .idx(mark_dirty_idx), .oh(dset_oh)
    );
    nclk_onehot #(.N(NUM_FRAMES), .W(IDX_W)) u_dclr_dec (
        .en(wb_done_valid), .idx(wb_done_idx), .oh(dclr_oh)
    );

    // inspect the frame under the hand
    always_comb begin
        sweeping  = (ctrl_q.state == HAND_SWEEP);
        seen_used = use_v[ctrl_q.hand] | ref_oh[ctrl_q.hand];
        cur_dirty = dirty_v[ctrl_q.hand];
        age_n     = {1'b0, cnt_v[ctrl_q.hand]} + 1'b1;
        thresh    = cur_dirty ? DIRTY_T : CLEAN_T;
        hit       = sweeping && !seen_used && (age_n >= thresh);
        raise_wb  = sweeping && !seen_used && !hit && cur_dirty && (age_n == WB_T);
        hand_next = (ctrl_q.hand == LAST_IDX) ? '0 : ctrl_q.hand + 1'b1;
    end

    always_comb begin
        ctrl_d    = ctrl_q;
        ctrl_d.vv = 1'b0;
        ctrl_d.wv = 1'b0;
        unique case (ctrl_q.state)
            HAND_IDLE: begin
                if (victim_req) begin
                    ctrl_d.state = HAND_SWEEP;
                end
            end
            HAND_SWEEP: begin
                ctrl_d.hand = hand_next;
                if (hit) begin
                    ctrl_d.state = HAND_IDLE;
                    ctrl_d.vv    = 1'b1;
                    ctrl_d.vidx  = ctrl_q.hand;
                end
                if (raise_wb) begin
                    ctrl_d.wv   = 1'b1;
                    ctrl_d.widx = ctrl_q.hand;
                end
            end
            default: ctrl_d.state = HAND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: HAND_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic at_hand;
        assign at_hand   = sweeping && (ctrl_q.hand == IDX_W'(i));
        assign take_v[i] = at_hand && hit;
        assign skip_v[i] = at_hand && seen_used;
        assign age_v[i]  = at_hand && !seen_used && !hit;

        nclk_frame #(.CNT_W(CNT_W)) u_frame (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_hit   (ref_oh[i]),
            .dirty_set (dset_oh[i]),
            .dirty_clr (dclr_oh[i]),
            .skip      (skip_v[i]),
            .age       (age_v[i]),
            .take      (take_v[i]),
            .use_o     (use_v[i]),
            .dirty_o   (dirty_v[i]),
            .cnt_o     (cnt_v[i])
        );
    end

    assign busy_w       = sweeping;
    assign hand_w       = ctrl_q.hand;
    assign victim_valid = ctrl_q.vv;
    assign victim_idx   = ctrl_q.vidx;
    assign wb_req_valid = ctrl_q.wv;
    assign wb_req_idx   = ctrl_q.widx;

endmodule

// File: rtl/nclk_checker.sv
module nclk_checker #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [IDX_W-1:0] hand,
    input logic             victim_valid,
    input logic [IDX_W-1:0] victim_idx,
    input logic             wb_req_valid
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    AST_VICTIM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid); // R3

    AST_HAND_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (hand == $past(hand))); // R3

    AST_VICTIM_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(busy)); // R11

    AST_NO_WB_WITH_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        !(victim_valid && wb_req_valid)); // R6

    AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand == ((victim_idx == LAST_IDX) ? '0 : victim_idx + 1'b1))); // R8

    AST_VICTIM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (victim_idx <= LAST_IDX)); // R5

endmodule

bind nth_clock_victim nclk_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
) u_nclk_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy_w),
    .hand         (hand_w),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx),
    .wb_req_valid (wb_req_valid)
);

// File: tb/tb_nth_clock_victim.sv
module tb_nth_clock_victim;

    localparam int CLK_PERIOD = 10;
    localparam int F          = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_valid = 1'b0, mark_dirty_valid = 1'b0, wb_done_valid = 1'b0, victim_req = 1'b0;
    logic [IW-1:0] touch_idx = '0, mark_dirty_idx = '0, wb_done_idx = '0;
    logic          victim_valid, wb_req_valid;
    logic [IW-1:0] victim_idx, wb_req_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // frame-level model of the sweep rules
    int m_use [F];
    int m_dirty [F];
    int m_cnt [F];
    int m_hand;
    bit m_search;
    bit e_vv, e_wv;
    int e_vi, e_wi;

    always #(CLK_PERIOD/2) clk = ~clk;

    nth_clock_victim #(.NUM_FRAMES(F)) dut (
        .clk(clk), .rst_n(rst_n),
        .touch_valid(touch_valid), .touch_idx(touch_idx),
        .mark_dirty_valid(mark_dirty_valid), .mark_dirty_idx(mark_dirty_idx),
        .wb_done_valid(wb_done_valid), .wb_done_idx(wb_done_idx),
        .victim_req(victim_req),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .wb_req_valid(wb_req_valid), .wb_req_idx(wb_req_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit rv, input int ri, input bit dv, input int di,
                              input bit cv, input int ci, input bit q);
        e_vv = 0;
        e_wv = 0;
        if (m_search) begin
            int h;
            int age;
            int th;
            bit used;
            h    = m_hand;
            used = (m_use[h] != 0) || (rv && ri == h);
            age  = m_cnt[h] + 1;
            th   = (m_dirty[h] != 0) ? 2 : 1;
            if (used) begin
                m_cnt[h] = 0;
                m_use[h] = 0;
            end else if (age >= th) begin
                m_cnt[h]   = 0;
                m_use[h]   = 1;
                m_dirty[h] = 0;
                e_vv = 1;
                e_vi = h;
                m_search = 0;
            end else begin
                m_cnt[h] = age;
                if (m_dirty[h] != 0 && age == 1) begin
                    e_wv = 1;
                    e_wi = h;
                end
            end
            m_hand = (h + 1) % F;
        end else if (q) begin
            m_search = 1;
        end
        if (rv) m_use[ri] = 1;
        if (cv) m_dirty[ci] = 0;
        if (dv) m_dirty[di] = 1;
    endtask

    // drive one cycle of inputs, then compare the strobes after the edge
    task automatic step(input bit rv, input int ri, input bit dv, input int di,
                        input bit cv, input int ci, input bit q);
        touch_valid      = rv;  touch_idx      = IW'(ri);
        mark_dirty_valid = dv;  mark_dirty_idx = IW'(di);
        wb_done_valid    = cv;  wb_done_idx    = IW'(ci);
        victim_req       = q;
        model_step(rv, ri, dv, di, cv, ci, q);
        @(posedge clk);
        @(negedge clk);
        chk(victim_valid == e_vv, "R5 victim strobe vs model", int'(victim_valid), int'(e_vv));
        if (e_vv) chk(int'(victim_idx) == e_vi, "R5 victim index vs model", int'(victim_idx), e_vi);
        chk(wb_req_valid == e_wv, "R6 write-back strobe vs model", int'(wb_req_valid), int'(e_wv));
        if (e_wv) chk(int'(wb_req_idx) == e_wi, "R6 write-back index vs model", int'(wb_req_idx), e_wi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic get_victim(input int exp_idx, input int exp_lat, input string tag,
                              input bit ref_first, input int ref_i, input bit req_again,
                              output int wb_seen);
        int lat;
        int vi;
        bit got;
        lat = 0; vi = -1; got = 0; wb_seen = -1;
        step(0, 0, 0, 0, 0, 0, 1);
        while (!got && lat < 40) begin
            lat++;
            step(ref_first && lat == 1, ref_i, 0, 0, 0, 0, req_again && lat == 1);
            if (wb_req_valid) wb_seen = int'(wb_req_idx);
            if (victim_valid) begin
                got = 1;
                vi  = int'(victim_idx);
            end
        end
        chk(got && vi == exp_idx, {tag, " victim index"}, vi, exp_idx);
        chk(lat == exp_lat, {tag, " search cycles"}, lat, exp_lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wb;
        int cnt;
        void'($urandom(32'd4242));
        for (int i = 0; i < F; i++) begin
            m_use[i] = 0; m_dirty[i] = 0; m_cnt[i] = 0;
        end
        m_hand = 0;
        m_search = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(victim_valid == 1'b0, "R1 victim strobe after reset", int'(victim_valid), 0);
        chk(wb_req_valid == 1'b0, "R1 write-back strobe after reset", int'(wb_req_valid), 0);

        // R3/R5: untouched frame 0 taken one cycle after the request edge
        get_victim(0, 1, "R3 R5 first search", 0, 0, 0, wb);
        idle(3);
        // R8: the hand has moved on to frame 1
        get_victim(1, 1, "R8 hand after victim", 0, 0, 0, wb);

        // R2/R4/R6: dirty frame 2 passed with write-back, touched frame 3 skipped
        step(0, 0, 1, 2, 0, 0, 0);
        step(1, 3, 0, 0, 0, 0, 0);
        get_victim(4, 3, "R2 R4 skip used frame", 0, 0, 0, wb);
        chk(wb == 2, "R6 write-back for dirty frame", wb, 2);

        // R9: dirtied then written back before the hand arrives -> clean, taken now
        step(0, 0, 1, 5, 0, 0, 0);
        step(0, 0, 0, 0, 1, 5, 0);
        get_victim(5, 1, "R9 cleaned frame", 0, 0, 0, wb);
        chk(wb == -1, "R9 no write-back after completion", wb, -1);

        // R7/R11: every frame used, hand at 6; second request mid-search ignored
        for (int i = 0; i < F; i++) step(1, i, 0, 0, 0, 0, 0);
        get_victim(6, 9, "R7 full revolution", 0, 0, 1, wb);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            if (victim_valid) cnt++;
        end
        chk(cnt == 0, "R11 extra request ignored", cnt, 0);

        // R10: reference to frame 7 while under the hand; wrap to 0 (R8)
        get_victim(0, 2, "R10 R8 reference under hand", 1, 7, 0, wb);

        // random traffic against the model
        for (int n = 0; n < 6000; n++) begin
            step(($urandom % 4) == 0, int'($urandom % F),
                 ($urandom % 8) == 0, int'($urandom % F),
                 ($urandom % 8) == 0, int'($urandom % F),
                 ($urandom % 12) == 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule